// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block turns an 8-bit up-counter and one shared comparator into a repeating pulse generator. A period register fixes how long each cycle lasts. A width register fixes how long the output stays active at the start of each cycle. The comparator looks at only one of the two registers at a time. Each match hands it over to the other register. Only a period match clears the counter and raises the one-cycle interrupt strobe.

The counter advances only on system-clock cycles where an external prescaler strobe is high. A new width value is first held in a staging register. It reaches the compare register only after three further prescaler strobes. Each time counting stops, the block forgets that the width was loaded. Software must write the width again after every restart, even with an unchanged value. Until it does, the output stays active for the whole period.

Top module: `pwm_dual_timer`

## Requirements
- R1: After reset `pulseOut` and `irqPulse` are 0, the counter is 0, and the comparator targets the period register.
- R2: The counter moves up by exactly one only on clock edges where both `runEn` and `tickEn` are 1. On every other edge it keeps its value, so with one strobe every K cycles all timings scale by K.
- R3: On a strobe with the period register as target and counter equal to N, the counter returns to 0, `pulseOut` becomes 1, and `irqPulse` is 1 for exactly one clock cycle. One period lasts N+1 strobes.
- R4: On a strobe with the width register as target and counter equal to M, `pulseOut` becomes 0 and the target returns to the period register. The counter keeps counting and `irqPulse` stays 0. For M < N the output is active for M+1 strobes of each period.
- R5: A width write goes into a staging register. It is copied into the compare register on the third strobe after the write cycle. A strobe in the write cycle itself is not counted. A compare on that third strobe still uses the old value.
- R6: While `runEn` is 0, the counter is held at 0, `pulseOut` and `irqPulse` are 0 from the next cycle on, and the target is reset to the period register.
- R7: Stopping (a 1-to-0 change of `runEn`) marks the width as not loaded. While it is not loaded, a period match keeps the period register as target, so `pulseOut` stays 1 through the whole period. A completed width transfer marks it loaded again.
- R8: A period write is visible to the very next compare, with no staging.
- R9: After `runEn` rises, the first compare is against the period register. The first interrupt comes N+1 strobes after the enabling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Count strobe from the prescaler |
| runEn | input | 1 | Counting enable |
| periodWr | input | 1 | Write strobe for the period register |
| periodIn | input | CNT_W | Period value N |
| widthWr | input | 1 | Write strobe for the width staging register |
| widthIn | input | CNT_W | Width value M |
| pulseOut | output | 1 | PWM output, 1 = active |
| irqPulse | output | 1 | One-cycle strobe on each period match |

## Verification
The bench builds the block with its defaults: an 8-bit counter and a three-strobe width transfer. The 8-bit counter keeps every period short enough to measure many whole periods edge by edge. Prescaler spacings of 1, 2 and 3 cycles show that all timing follows the strobes and not the clock. The three-strobe transfer is hit exactly: with a period of four strobes the load lands on the same edge as the first match, and with five it lands one edge before. The two runs must behave differently.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic {
    TGT_PERIOD = 1'b0,
    TGT_WIDTH  = 1'b1
  } cmpTarget_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic selWidth;
    logic loadWidth;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_timer_dpath.sv
module pwm_timer_dpath
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       stb,
  input  logic             periodWr,
  input  logic [CNT_W-1:0] periodIn,
  input  logic             widthWr,
  input  logic [CNT_W-1:0] widthIn,
  output logic             match
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodReg;
  logic [CNT_W-1:0] widthStage;
  logic [CNT_W-1:0] widthActive;
  logic [CNT_W-1:0] cmpVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      periodReg   <= '0;
      widthStage  <= '0;
      widthActive <= '0;
    end else begin
      if (periodWr)      periodReg   <= periodIn;
      if (widthWr)       widthStage  <= widthIn;
      if (stb.loadWidth) widthActive <= widthStage;
      if (stb.cntClear)    cnt <= '0;
      else if (stb.cntInc) cnt <= cnt + 1'b1;
    end
  end

  // One shared comparator; its operand is picked by control
  assign cmpVal = stb.selWidth ? widthActive : periodReg;
  assign match  = (cnt == cmpVal);

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.cntClear && stb.cntInc));

  assert_clear_to_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntClear |=> (cnt == '0));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntInc |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int XFER_TICKS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       runEn,
  input  logic       widthWr,
  input  logic       match,
  output pwmStrobe_t stb,
  output logic       pulseOut,
  output logic       irqPulse
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int PEND_W = $clog2(XFER_TICKS + 1);

  cmpTarget_t        target;
  logic [PEND_W-1:0] pendCnt;
  logic              widthValid;
  logic              runPrev;
  logic              tick;
  logic              periodHit;
  logic              widthHit;
  logic              loadNow;
  logic              stopEdge;

  assign tick      = runEn && tickEn;
  assign periodHit = tick && match && (target == TGT_PERIOD);
  assign widthHit  = tick && match && (target == TGT_WIDTH);
  assign loadNow   = tickEn && !widthWr && (pendCnt == PEND_W'(1));
  assign stopEdge  = runPrev && !runEn;

  always_comb begin
    stb.cntClear  = !runEn || periodHit;
    stb.cntInc    = tick && !periodHit;
    stb.selWidth  = (target == TGT_WIDTH);
    stb.loadWidth = loadNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target     <= TGT_PERIOD;
      pulseOut   <= 1'b0;
      irqPulse   <= 1'b0;
      pendCnt    <= '0;
      widthValid <= 1'b0;
      runPrev    <= 1'b0;
    end else begin
      runPrev  <= runEn;
      irqPulse <= periodHit;

      if (!runEn) begin
        target   <= TGT_PERIOD;
        pulseOut <= 1'b0;
      end else if (periodHit) begin
        pulseOut <= 1'b1;
        target   <= widthValid ? TGT_WIDTH : TGT_PERIOD;
      end else if (widthHit) begin
        pulseOut <= 1'b0;
        target   <= TGT_PERIOD;
      end

      // Transfer delay, counted in strobes; a write restarts it
      if (widthWr)                      pendCnt <= PEND_W'(XFER_TICKS);
      else if (tickEn && pendCnt != '0) pendCnt <= pendCnt - 1'b1;

      if (stopEdge)     widthValid <= 1'b0;
      else if (loadNow) widthValid <= 1'b1;
    end
  end

  assert_stop_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!pulseOut && !irqPulse));

  assert_irq_from_period_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(target) == TGT_PERIOD));

  assert_width_needs_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (target == TGT_WIDTH) |-> widthValid);

  assert_load_after_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(widthValid) |-> ($past(pendCnt) == PEND_W'(1)));
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int XFER_TICKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             runEn,
  input  logic             periodWr,
  input  logic [CNT_W-1:0] periodIn,
  input  logic             widthWr,
  input  logic [CNT_W-1:0] widthIn,
  output logic             pulseOut,
  output logic             irqPulse
);
  timeunit 1ns;
  timeprecision 100ps;

  pwmStrobe_t stb;
  logic       match;

  pwm_timer_ctrl #(.XFER_TICKS(XFER_TICKS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .runEn    (runEn),
    .widthWr  (widthWr),
    .match    (match),
    .stb      (stb),
    .pulseOut (pulseOut),
    .irqPulse (irqPulse)
  );

  pwm_timer_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .periodWr (periodWr),
    .periodIn (periodIn),
    .widthWr  (widthWr),
    .widthIn  (widthIn),
    .match    (match)
  );
endmodule

// File: tb/sim_pwm_dual_timer.sv
module sim_pwm_dual_timer;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       runEn = 1'b0;
  logic       periodWr = 1'b0;
  logic       widthWr = 1'b0;
  logic [7:0] periodIn = '0;
  logic [7:0] widthIn = '0;
  logic       pulseOut;
  logic       irqPulse;

  int tickDiv = 1;
  int phase = 0;
  int checks = 0;
  int fails = 0;

  // Vector table: period N, width M, strobe spacing K
  localparam int NV = 6;
  localparam int VN [NV] = '{4, 9, 7, 3, 15, 1};
  localparam int VM [NV] = '{1, 0, 6, 1, 4, 0};
  localparam int VK [NV] = '{1, 1, 1, 3, 2, 1};

  pwm_dual_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .runEn(runEn),
    .periodWr(periodWr), .periodIn(periodIn),
    .widthWr(widthWr), .widthIn(widthIn),
    .pulseOut(pulseOut), .irqPulse(irqPulse)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (phase + 1 >= tickDiv) phase = 0;
    else phase = phase + 1;
    tickEn = (phase == 0);
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrPeriod(input int v);
    periodIn = 8'(v); periodWr = 1'b1;
    @(negedge clk);
    periodWr = 1'b0;
  endtask

  task automatic wrWidth(input int v);
    widthIn = 8'(v); widthWr = 1'b1;
    @(negedge clk);
    widthWr = 1'b0;
  endtask

  task automatic waitIrq(output int cyc);
    cyc = 0;
    while (irqPulse !== 1'b1) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // From one interrupt sample up to the next: cycles, active cycles, interrupt samples
  task automatic measure(output int per, output int hi, output int irqs);
    per = 0; hi = 0; irqs = 0;
    do begin
      if (pulseOut) hi++;
      if (irqPulse) irqs++;
      per++;
      @(negedge clk);
    end while (irqPulse !== 1'b1);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c, per, hi, irqs;
    // R1: reset state
    stepN(3);
    check("R1", "pulseOut in reset", int'(pulseOut), 0);
    check("R1", "irqPulse in reset", int'(irqPulse), 0);
    rstN = 1'b1;
    stepN(3);
    check("R6", "pulseOut idle", int'(pulseOut), 0);

    // Table walk: R2, R3, R4 over several N, M, K
    for (int i = 0; i < NV; i++) begin
      runEn = 1'b0;
      stepN(2);
      tickDiv = VK[i];
      wrPeriod(VN[i]);
      wrWidth(VM[i]);
      stepN(4 * VK[i] + 4);
      runEn = 1'b1;
      waitIrq(c);
      measure(per, hi, irqs);
      check("R3", $sformatf("period vec%0d", i), per, (VN[i] + 1) * VK[i]);
      check("R4", $sformatf("active width vec%0d", i), hi, (VM[i] + 1) * VK[i]);
      check("R3", $sformatf("irq samples vec%0d", i), irqs, 1);
    end

    // R9: first interrupt N+1 strobes after enable
    runEn = 1'b0; tickDiv = 1;
    stepN(2);
    wrPeriod(6);
    wrWidth(2);
    stepN(6);
    runEn = 1'b1;
    waitIrq(c);
    check("R9", "cycles to first irq", c, 7);

    // R5 case A: load lands on the first match edge -> stays unloaded
    runEn = 1'b0;
    stepN(2);
    wrPeriod(3);
    stepN(2);
    widthIn = 8'd0; widthWr = 1'b1; runEn = 1'b1;
    @(negedge clk);
    widthWr = 1'b0;
    waitIrq(c);
    check("R9", "first irq N=3", c, 3);
    measure(per, hi, irqs);
    check("R5", "load on match edge, active cycles", hi, 4);
    check("R5", "period N=3", per, 4);

    // R5 case B: load one edge before the first match -> width used
    runEn = 1'b0;
    stepN(2);
    wrPeriod(4);
    stepN(2);
    widthIn = 8'd0; widthWr = 1'b1; runEn = 1'b1;
    @(negedge clk);
    widthWr = 1'b0;
    waitIrq(c);
    measure(per, hi, irqs);
    check("R5", "load before match, active cycles", hi, 1);
    check("R5", "period N=4", per, 5);

    // R7: restart without reload keeps output active whole period
    runEn = 1'b0;
    stepN(2);
    runEn = 1'b1;
    waitIrq(c);
    measure(per, hi, irqs);
    check("R7", "unloaded active cycles", hi, 5);
    check("R7", "unloaded period", per, 5);
    wrWidth(1);
    waitIrq(c);
    measure(per, hi, irqs);
    check("R7", "after reload active cycles", hi, 2);

    // R8: period write takes effect at the next compare
    wrPeriod(7);
    waitIrq(c);
    check("R8", "spacing after period write", c + 1, 8);
    measure(per, hi, irqs);
    check("R8", "new period", per, 8);
    check("R4", "width kept", hi, 2);

    // R6: stop while active, then restart from zero
    check("R6", "active before stop", int'(pulseOut), 1);
    runEn = 1'b0;
    @(negedge clk);
    check("R6", "pulseOut after stop", int'(pulseOut), 0);
    check("R6", "irqPulse after stop", int'(irqPulse), 0);
    stepN(3);
    runEn = 1'b1;
    waitIrq(c);
    check("R6", "restart from zero", c, 8);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule